// File: doc/BRIEF.md
# Auto-Incrementing Scratchpad RAM Port

This block is a byte-wide scratch memory that sits on a processor's shared data bus. A bus cycle carries three things: a 4-bit select code, a direction level and a data byte. The block decodes the select code into one-hot strobes. Two of those strobes act on the memory. The address-load strobe copies the data byte into an internal pointer. The transfer strobe moves one byte between the bus and the RAM word that the pointer currently names.

Each transfer advances the pointer by one. A block of bytes can therefore be streamed in or out after a single address load, with no further addressing. Read data is presented in the same cycle as the strobe, together with a valid flag. All state changes take effect on the rising clock edge.

Top module: `scratch_ram_port`

## Requirements
- R1: While `bus_cycle` is high, `sel_strobe` has exactly one bit set, at index `bus_sel`. While `bus_cycle` is low, `sel_strobe` is all zero.
- R2: A cycle with select code 4 and `bus_wr` high (write) loads `bus_wdata` into `cur_addr` at the next rising edge.
- R3: A cycle with select code 4 and `bus_wr` low (read) is ignored, and `cur_addr` keeps its value.
- R4: A cycle with select code 1 and `bus_wr` high stores `bus_wdata` at RAM word `cur_addr`, and `cur_addr` advances by one at the same edge.
- R5: A cycle with select code 1 and `bus_wr` low presents RAM word `cur_addr` on `bus_rdata` with `bus_rvalid` high in that same cycle, and `cur_addr` advances by one at the following edge.
- R6: The pointer wraps from 0xFF to 0x00 when it advances.
- R7: Cycles with any select code other than 1 or 4 change neither `cur_addr` nor any RAM word, in either direction.
- R8: A synchronous reset sets `cur_addr` to 0 and leaves RAM contents unchanged.
- R9: `bus_rvalid` is high only during a read transfer, and `bus_rdata` is zero whenever `bus_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_cycle | input | 1 | A bus cycle is active this clock |
| bus_sel | input | 4 | Device select code |
| bus_wr | input | 1 | Direction: 1 = write, 0 = read |
| bus_wdata | input | 8 | Byte driven by the processor |
| bus_rdata | output | 8 | Byte returned on a read transfer |
| bus_rvalid | output | 1 | `bus_rdata` holds RAM data this cycle |
| sel_strobe | output | 16 | One-hot decoded select strobes |
| cur_addr | output | 8 | Current RAM address pointer |

## Verification
The bench fills every one of the 256 words in one streamed burst, using a position-dependent byte pattern. It then reads the whole array back in a second burst. A pointer that skips, repeats or fails to wrap shows up as a mismatch at a known position. Both directions of all sixteen select codes are swept, and each unused code carries a poison byte. A stray write is exposed by a readback of the affected word, and a stray pointer move is exposed by `cur_addr`. Scattered address loads, a read-direction load attempt and a reset taken in the middle of a run separate loading from stepping. They also separate clearing the pointer from clearing the memory.

// File: rtl/scratch_pkg.sv
package scratch_pkg;

   // Kind of action a decoded bus cycle requests from the storage side.
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } scr_op_e;

   // True when the requested action moves a byte and so steps the pointer.
   function automatic logic op_steps(input scr_op_e op);
      return (op == OP_WRITE) || (op == OP_READ);
   endfunction

endpackage

// File: rtl/scr_sel_decode.sv
module scr_sel_decode
   import scratch_pkg::*;
#(
   parameter int SEL_W     = 4,
   parameter int LOAD_CODE = 4,
   parameter int XFER_CODE = 1,
   localparam int N_SEL    = 1 << SEL_W
) (
   input  logic             cycle_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             wr_i,
   output logic [N_SEL-1:0] strobe_o,
   output scr_op_e          op_o
);

   if (LOAD_CODE < 0 || LOAD_CODE >= N_SEL) begin : g_bad_load
      $error("scr_sel_decode: LOAD_CODE outside select range");
   end
   if (XFER_CODE < 0 || XFER_CODE >= N_SEL) begin : g_bad_xfer
      $error("scr_sel_decode: XFER_CODE outside select range");
   end
   if (LOAD_CODE == XFER_CODE) begin : g_same_code
      $error("scr_sel_decode: load and transfer codes must differ");
   end

   // One comparator per output line.
   for (genvar i = 0; i < N_SEL; i++) begin : g_line
      assign strobe_o[i] = cycle_i && (sel_i == SEL_W'(i));
   end

   always_comb begin
      op_o = OP_NONE;
      if (strobe_o[LOAD_CODE] && wr_i) begin
         op_o = OP_LOAD;
      end else if (strobe_o[XFER_CODE]) begin
         op_o = wr_i ? OP_WRITE : OP_READ;
      end
   end

endmodule

// File: rtl/scr_addr_ptr.sv
module scr_addr_ptr
   import scratch_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  scr_op_e           op_i,
   input  logic [DATA_W-1:0] load_i,
   output logic [ADDR_W-1:0] ptr_o
);

   if (ADDR_W > DATA_W) begin : g_bad_width
      $error("scr_addr_ptr: pointer wider than the data bus cannot be loaded");
   end

   logic [ADDR_W-1:0] load_addr;

   // Pick the load path by width: a narrower pointer takes the low bits.
   if (ADDR_W == DATA_W) begin : g_full
      assign load_addr = load_i;
   end else begin : g_trunc
      logic [DATA_W-ADDR_W-1:0] unused_hi;
      assign load_addr = load_i[ADDR_W-1:0];
      assign unused_hi = load_i[DATA_W-1:ADDR_W];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr_o <= '0;
      end else if (op_i == OP_LOAD) begin
         ptr_o <= load_addr;
      end else if (op_steps(op_i)) begin
         ptr_o <= ptr_o + 1'b1;
      end
   end

endmodule

// File: rtl/scr_byte_array.sv
module scr_byte_array #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   if (DEPTH > 4096) begin : g_too_deep
      $error("scr_byte_array: depth exceeds supported range");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   // No reset: contents survive a pointer reset.
   always_ff @(posedge clk) begin
      if (we_i) begin
         mem[addr_i] <= wdata_i;
      end
   end

   assign rdata_o = mem[addr_i];

endmodule

// File: rtl/scratch_ram_port.sv
module scratch_ram_port
   import scratch_pkg::*;
#(
   parameter int SEL_W     = 4,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int LOAD_CODE = 4,
   parameter int XFER_CODE = 1,
   localparam int N_SEL    = 1 << SEL_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_cycle,
   input  logic [SEL_W-1:0]  bus_sel,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   output logic [N_SEL-1:0]  sel_strobe,
   output logic [ADDR_W-1:0] cur_addr
);

   scr_op_e           op;
   logic [DATA_W-1:0] ram_q;

   scr_sel_decode #(
      .SEL_W     (SEL_W),
      .LOAD_CODE (LOAD_CODE),
      .XFER_CODE (XFER_CODE)
   ) dec_i (
      .cycle_i  (bus_cycle),
      .sel_i    (bus_sel),
      .wr_i     (bus_wr),
      .strobe_o (sel_strobe),
      .op_o     (op)
   );

   scr_addr_ptr #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) ptr_i (
      .clk    (clk),
      .rst    (rst),
      .op_i   (op),
      .load_i (bus_wdata),
      .ptr_o  (cur_addr)
   );

   scr_byte_array #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) ram_i (
      .clk     (clk),
      .we_i    (op == OP_WRITE && !rst),
      .addr_i  (cur_addr),
      .wdata_i (bus_wdata),
      .rdata_o (ram_q)
   );

   assign bus_rvalid = (op == OP_READ);
   assign bus_rdata  = bus_rvalid ? ram_q : '0;

endmodule

// File: rtl/scratch_ram_port_chk.sv
module scratch_ram_port_chk #(
   parameter int SEL_W     = 4,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int LOAD_CODE = 4,
   parameter int XFER_CODE = 1,
   localparam int N_SEL    = 1 << SEL_W
) (
   input logic              clk,
   input logic              rst,
   input logic              bus_cycle,
   input logic [SEL_W-1:0]  bus_sel,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bus_rvalid,
   input logic [N_SEL-1:0]  sel_strobe,
   input logic [ADDR_W-1:0] cur_addr
);

   logic is_load, is_xfer;
   assign is_load = bus_cycle && (bus_sel == SEL_W'(LOAD_CODE));
   assign is_xfer = bus_cycle && (bus_sel == SEL_W'(XFER_CODE));

   AST_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
      bus_cycle |-> ($countones(sel_strobe) == 1 && sel_strobe[bus_sel])); // R1
   AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
      !bus_cycle |-> (sel_strobe == '0)); // R1
   AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
      (is_load && bus_wr) |=> (cur_addr == $past(bus_wdata[ADDR_W-1:0]))); // R2
   AST_LOAD_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (is_load && !bus_wr) |=> $stable(cur_addr)); // R3
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
      is_xfer |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1))); // R6
   AST_OTHER_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
      (bus_cycle && !is_load && !is_xfer) |=> $stable(cur_addr)); // R7
   AST_RESET_PTR: assert property (@(posedge clk)
      rst |=> (cur_addr == '0)); // R8
   AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
      bus_rvalid |-> (is_xfer && !bus_wr)); // R9
   AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
      !bus_rvalid |-> (bus_rdata == '0)); // R9

endmodule

bind scratch_ram_port scratch_ram_port_chk #(
   .SEL_W     (SEL_W),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .LOAD_CODE (LOAD_CODE),
   .XFER_CODE (XFER_CODE)
) chk_i (
   .clk        (clk),
   .rst        (rst),
   .bus_cycle  (bus_cycle),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .bus_rvalid (bus_rvalid),
   .sel_strobe (sel_strobe),
   .cur_addr   (cur_addr)
);

// File: tb/scratch_ram_port_tb.sv
module scratch_ram_port_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic        bus_cycle;
   logic [3:0]  bus_sel;
   logic        bus_wr;
   logic [7:0]  bus_wdata;
   logic [7:0]  bus_rdata;
   logic        bus_rvalid;
   logic [15:0] sel_strobe;
   logic [7:0]  cur_addr;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [7:0] ref_mem [256];
   logic [7:0] ref_ptr;

   // Sampled outputs of the most recent bus cycle.
   logic [7:0]  s_rdata;
   logic        s_rvalid;
   logic [15:0] s_strobe;

   always #4 clk = ~clk;

   scratch_ram_port dut_i (
      .clk        (clk),
      .rst        (rst),
      .bus_cycle  (bus_cycle),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .bus_rvalid (bus_rvalid),
      .sel_strobe (sel_strobe),
      .cur_addr   (cur_addr)
   );

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 11) ^ (a >> 3));
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Drive one bus cycle at the falling edge and sample the same-cycle outputs.
   // After the rising edge the cycle is removed, so cur_addr is settled on return.
   task automatic bus_op(input logic [3:0] s, input logic w, input logic [7:0] d);
      @(negedge clk);
      bus_cycle = 1'b1; bus_sel = s; bus_wr = w; bus_wdata = d;
      #1;
      s_rdata = bus_rdata; s_rvalid = bus_rvalid; s_strobe = sel_strobe;
      @(posedge clk);
      #1;
      bus_cycle = 1'b0;
   endtask

   task automatic load_addr(input logic [7:0] a);
      bus_op(4'd4, 1'b1, a);
      ref_ptr = a;
      check(cur_addr == a, "R2", cur_addr, a);
   endtask

   task automatic read_one(input string req);
      logic [7:0] e;
      e = ref_mem[ref_ptr];
      bus_op(4'd1, 1'b0, 8'h00);
      check(s_rvalid && s_rdata == e, req, s_rdata, e);
      ref_ptr = ref_ptr + 8'd1;
      check(cur_addr == ref_ptr, "R5", cur_addr, ref_ptr);
   endtask

   initial begin
      rst = 1'b1; bus_cycle = 1'b0; bus_sel = '0; bus_wr = 1'b0; bus_wdata = '0;
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      @(negedge clk);
      // Reset state (R8) and idle outputs (R1, R9)
      check(cur_addr == 8'h00, "R8", cur_addr, 0);
      check(sel_strobe == '0, "R1", sel_strobe, 0);
      check(!bus_rvalid && bus_rdata == 8'h00, "R9", bus_rdata, 0);

      // Stream-fill the full array after a single load (R4, R6)
      load_addr(8'h00);
      for (int a = 0; a < 256; a++) begin
         bus_op(4'd1, 1'b1, pat(a));
         ref_mem[a] = pat(a);
         check(!s_rvalid, "R9", s_rvalid, 0);
         ref_ptr = ref_ptr + 8'd1;
         check(cur_addr == ref_ptr, "R4", cur_addr, ref_ptr);
      end
      check(cur_addr == 8'h00, "R6", cur_addr, 0);

      // Stream-read the whole array; pointer wraps again (R5, R6)
      for (int a = 0; a < 256; a++) read_one("R5");
      check(cur_addr == 8'h00, "R6", cur_addr, 0);

      // Scattered loads with a read on each (R2, R5)
      for (int k = 0; k < 24; k++) begin
         load_addr(8'((k * 53 + 7) & 8'hFF));
         read_one("R5");
      end

      // Wrap at the top during a write (R6)
      load_addr(8'hFF);
      bus_op(4'd1, 1'b1, 8'h5A);
      ref_mem[255] = 8'h5A;
      check(cur_addr == 8'h00, "R6", cur_addr, 0);

      // Read-direction load is ignored (R3)
      load_addr(8'h40);
      bus_op(4'd4, 1'b0, 8'h99);
      check(cur_addr == 8'h40, "R3", cur_addr, 8'h40);
      check(!s_rvalid, "R3", s_rvalid, 0);

      // Sweep every select code in both directions (R1, R7)
      for (int c = 0; c < 16; c++) begin
         for (int w = 0; w < 2; w++) begin
            load_addr(8'(c * 16 + w + 2));
            bus_op(4'(c), 1'(w), 8'hEE);
            check(s_strobe == (16'h1 << c), "R1", s_strobe, 16'h1 << c);
            if (c == 4 && w == 1) begin
               ref_ptr = 8'hEE;
            end else if (c == 1) begin
               if (w == 1) ref_mem[ref_ptr] = 8'hEE;
               else check(s_rvalid && s_rdata == ref_mem[ref_ptr], "R5", s_rdata, ref_mem[ref_ptr]);
               ref_ptr = ref_ptr + 8'd1;
            end else begin
               check(!s_rvalid && s_rdata == 8'h00, "R9", s_rdata, 0);
            end
            check(cur_addr == ref_ptr, "R7", cur_addr, ref_ptr);
            // Word at the loaded address must hold whatever the model says
            load_addr(8'(c * 16 + w + 2));
            read_one("R7");
         end
      end

      // Mid-run reset clears pointer, keeps RAM (R8)
      load_addr(8'h77);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      rst = 1'b0;
      ref_ptr = 8'h00;
      check(cur_addr == 8'h00, "R8", cur_addr, 0);
      read_one("R8");
      read_one("R8");

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (50000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule